// File: doc/BRIEF.md
# SPI Slave Register Bank Frontend

This block is an SPI slave that gives an external master read and write access to a bank of 64 registers, each 24 bits wide. Every transaction is a single 32-bit frame, shifted most significant bit first while chip select is high. The frame carries a write flag, a 6-bit register address and a 24-bit data field. The link is full duplex: during the same frame the slave shifts the addressed register's current contents back to the master in the low 24 bits.

SCLK, MOSI and chip select are brought into the system clock domain through two-flop synchronizers. SCLK is oversampled there, so the block runs from one system clock and SCLK must be slow compared with it. A registered parallel read port lets internal logic read any register.

Top module: `spi_regfile_slave`

## Requirements
- R1: A frame is sampled on rising SCLK edges, MSB first. Frame bit 31 is the command (1 = write, 0 = read), bits 30..25 are the register address (0..63), and bits 23..0 are the data.
- R2: A write frame stores frame bits 23..0 into the addressed register, where the internal read port can read it.
- R3: In any complete frame, frame bits 23..0 on MISO carry the addressed register's value, MSB first. MISO changes after falling SCLK edges, so the master samples it on rising edges.
- R4: MISO frame bits 31..24 are driven as 0, and the value of input bit 24 has no effect on any register.
- R5: A frame during which chip select falls before the 32nd rising SCLK edge writes nothing. This includes a frame that stops after exactly 31 clocks.
- R6: A write takes effect at the 32nd rising SCLK edge and is visible on the internal port while chip select is still high.
- R7: While chip select is low, `spi_miso_oe` and `spi_miso` are 0. While chip select is high, `spi_miso_oe` is 1.
- R8: A read frame leaves the addressed register unchanged.
- R9: SCLK edges after the 32nd in one frame are ignored. They cause no further write, and MISO stays 0 during them.
- R10: While reset is asserted, and after it, `spi_miso` and `spi_miso_oe` are 0 until chip select rises.
- R11: `int_rdata` presents the register selected by `int_addr` one system clock after `int_addr` is applied.
- R12: On a write frame, MISO returns the register's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI inputs are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_mosi | input | 1 | Serial data from master |
| spi_cs | input | 1 | Chip select, active high |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | High while MISO is being driven |
| int_addr | input | 6 | Internal read address |
| int_rdata | output | 24 | Internal read data, one cycle after address |

## Verification
After a falling SCLK edge at the pins, the next MISO bit settles about three system clocks later: two synchronizer stages plus the output register. The bench drives SCLK with a half period of eight system clocks and captures MISO at the following rising edge, well after it has settled. A register write lands about five system clocks after the 32nd rising edge. The bench therefore waits a half period before probing the internal port, both with chip select still high and after it falls. The internal port is checked exactly one system clock after its address is applied.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  // Default geometry of the bank and the frame
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_DATA_W = 24;
  localparam int DEF_SYNC_STAGES = 2;

  // Command carried in the top frame bit
  typedef enum logic {
    CMD_READ  = 1'b0,
    CMD_WRITE = 1'b1
  } spi_cmd_e;

  // Frame width: command + address + one spare bit + data
  function automatic int frame_width(input int addr_w, input int data_w);
    return 2 + addr_w + data_w;
  endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso_q,
  output logic              miso_oe
);
  localparam int FRAME_W   = frame_width(ADDR_W, DATA_W);
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam int HDR_W     = FRAME_W - DATA_W;  // bits before data
  localparam int ADDR_DONE = 1 + ADDR_W;        // command + address
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_ADDR  = CNT_W'(ADDR_DONE - 1);
  localparam logic [CNT_W-1:0] CNT_HDR   = CNT_W'(HDR_W);

  logic               sclk_d;
  logic               rise, fall;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-2:0] shreg;
  logic [DATA_W-1:0]  tx;
  spi_cmd_e           cmd_bit;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise    = cs_s &  sclk_s & ~sclk_d;
  assign fall    = cs_s & ~sclk_s &  sclk_d;
  assign cmd_bit = spi_cmd_e'(shreg[FRAME_W-2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
      tx      <= '0;
      miso_q  <= 1'b0;
      miso_oe <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      miso_oe <= cs_s;
      if (!cs_s) begin
        bit_cnt <= '0;
        shreg   <= '0;
        tx      <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (rise && bit_cnt != CNT_FULL) begin
          shreg   <= {shreg[FRAME_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_ADDR) begin
            rd_en   <= 1'b1;
            rd_addr <= {shreg[ADDR_W-2:0], mosi_s};
          end
          if (bit_cnt == CNT_LAST && cmd_bit == CMD_WRITE) begin
            wr_en   <= 1'b1;
            wr_addr <= shreg[FRAME_W-3 -: ADDR_W];
            wr_data <= {shreg[DATA_W-2:0], mosi_s};
          end
        end
        if (fall) begin
          if (bit_cnt == CNT_HDR) begin
            miso_q <= rd_data[DATA_W-1];
            tx     <= {rd_data[DATA_W-2:0], 1'b0};
          end else if (bit_cnt > CNT_HDR && bit_cnt < CNT_FULL) begin
            miso_q <= tx[DATA_W-1];
            tx     <= {tx[DATA_W-2:0], 1'b0};
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  // R1: the bit counter never passes the frame length
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_FULL);

  // R5: a write is issued only on the edge that completes a full frame
  a_r5_write_full_frame: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> bit_cnt == CNT_FULL);

  // R9: at most one write strobe per frame
  a_r9_single_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R3: the register lookup fires once the address is complete
  a_r3_lookup_time: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> bit_cnt == CNT_W'(ADDR_DONE));

  // R4: header bits go out as zero
  a_r4_header_zero: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt < CNT_HDR) |-> !miso_q);
endmodule

// File: rtl/spi_rf_regbank.sv
module spi_rf_regbank
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] int_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single write port, kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read ports with synchronous output reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      int_rdata <= '0;
    end else begin
      if (rd_en) rd_data <= mem[rd_addr];
      int_rdata <= mem[int_addr];
    end
  end

  // R11: the internal port follows a steady address and an idle write port
  a_r11_port_stable: assert property (@(posedge clk) disable iff (rst)
    ($stable(int_addr) && !$past(wr_en) && !wr_en && !$past(rst)) |=> $stable(int_rdata));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [ADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0] int_rdata
);
  logic [2:0]        pins_s;
  logic              rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  spi_rf_sync #(
    .WIDTH (3),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({spi_cs, spi_sclk, spi_mosi}),
    .q  (pins_s)
  );

  spi_rf_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_frame (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (pins_s[2]),
    .sclk_s (pins_s[1]),
    .mosi_s (pins_s[0]),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .miso_q (spi_miso),
    .miso_oe(spi_miso_oe)
  );

  spi_rf_regbank #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .int_addr (int_addr),
    .int_rdata(int_rdata)
  );

  // R7: MISO is quiet whenever the output is not enabled
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !spi_miso_oe |-> !spi_miso);

  // R10: reset leaves the serial outputs low
  a_r10_reset_low: assert property (@(posedge clk)
    $past(rst) |-> (!spi_miso && !spi_miso_oe));
endmodule

// File: tb/test_spi_regfile_slave.sv
module test_spi_regfile_slave;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 24;
  localparam int FRAME_W = 32;
  localparam int HALF    = 8;
  localparam int NVEC    = 10;
  localparam int LIMIT   = 150000;

  typedef struct packed {
    logic [31:0] cmd;
    logic [7:0]  nclk;
    logic [5:0]  addr;
    logic [23:0] rx;
    logic [23:0] reg_exp;
  } vec_t;

  // Bank is preloaded with reg[a] = {a,a,a} (8-bit each) before the walk
  localparam vec_t VEC [NVEC] = '{
    '{32'h0A000000, 8'd32, 6'd5,  24'h050505, 24'h050505},  // R3 R8 read 5
    '{32'h8AABCDEF, 8'd32, 6'd5,  24'h050505, 24'hABCDEF},  // R2 R12 write 5
    '{32'h0A000000, 8'd32, 6'd5,  24'hABCDEF, 24'hABCDEF},  // R3 read back
    '{32'hFE000001, 8'd32, 6'd63, 24'h3F3F3F, 24'h000001},  // R1 top address
    '{32'h81FFFFFF, 8'd32, 6'd0,  24'h000000, 24'hFFFFFF},  // R4 bit 24 set
    '{32'h92123456, 8'd20, 6'd9,  24'h000000, 24'h090909},  // R5 short frame
    '{32'h94654321, 8'd40, 6'd10, 24'h0A0A0A, 24'h654321},  // R9 extra clocks
    '{32'h7E000000, 8'd32, 6'd63, 24'h000001, 24'h000001},  // R3 read 63
    '{32'h01000000, 8'd32, 6'd0,  24'hFFFFFF, 24'hFFFFFF},  // R4 read, bit 24 set
    '{32'h96777777, 8'd31, 6'd11, 24'h000000, 24'h0B0B0B}   // R5 31 clocks
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic cs = 1'b0;
  logic [ADDR_W-1:0] int_addr = '0;
  logic miso, miso_oe;
  logic [DATA_W-1:0] int_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  spi_regfile_slave i_spi_regfile_slave (
    .clk        (clk),
    .rst        (rst),
    .spi_sclk   (sclk),
    .spi_mosi   (mosi),
    .spi_cs     (cs),
    .spi_miso   (miso),
    .spi_miso_oe(miso_oe),
    .int_addr   (int_addr),
    .int_rdata  (int_rdata)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [31:0] cmd, input int nclk, input bit hold_cs,
                           output logic [31:0] rx, output logic extra);
    rx = '0;
    extra = 1'b0;
    cs = 1'b1;
    tick(4);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < FRAME_W) ? cmd[FRAME_W-1-i] : 1'b1;
      tick(HALF);
      sclk = 1'b1;
      if (i < FRAME_W) rx[FRAME_W-1-i] = miso;
      else extra = extra | miso;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    mosi = 1'b0;
    if (!hold_cs) begin
      cs = 1'b0;
      tick(8);
    end
  endtask

  task automatic int_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    int_addr = a;
    tick(1);
    d = int_rdata;
  endtask

  initial begin
    logic [31:0] rx;
    logic extra;
    logic [DATA_W-1:0] rd;

    // R10: outputs low during and right after reset
    tick(5);
    check("R10 miso in reset", 32'(miso), 32'h0);
    check("R10 miso_oe in reset", 32'(miso_oe), 32'h0);
    rst = 1'b0;
    tick(3);
    check("R10 miso after reset", 32'(miso), 32'h0);
    check("R7 miso_oe idle", 32'(miso_oe), 32'h0);

    // Preload reg[a] = {a,a,a}
    for (int a = 0; a < 64; a++) begin
      run_frame({1'b1, 6'(a), 1'b0, {3{8'(a)}}}, 32, 1'b0, rx, extra);
    end

    // R11: internal port one cycle after address
    int_read(6'd33, rd);
    check("R11 int port reg 33", 32'(rd), 32'h212121);
    int_read(6'd62, rd);
    check("R11 int port reg 62", 32'(rd), 32'h3E3E3E);

    // Table walk: R1 frame layout, R2/R3/R4/R5/R8/R9/R12
    for (int v = 0; v < NVEC; v++) begin
      run_frame(VEC[v].cmd, int'(VEC[v].nclk), 1'b0, rx, extra);
      if (VEC[v].nclk >= 8'd32) begin
        check($sformatf("R4 header zero vec %0d", v), 32'(rx[31:24]), 32'h0);
        check($sformatf("R1/R3/R12 returned data vec %0d", v), 32'(rx[23:0]), 32'(VEC[v].rx));
      end
      if (VEC[v].nclk > 8'd32)
        check($sformatf("R9 miso after 32nd clock vec %0d", v), 32'(extra), 32'h0);
      int_read(VEC[v].addr, rd);
      check($sformatf("R2/R5/R8/R9 register after vec %0d", v), 32'(rd), 32'(VEC[v].reg_exp));
    end

    // R7: outputs released after a frame that ended on a 1 bit
    check("R7 miso low after frame", 32'(miso), 32'h0);
    check("R7 miso_oe low after frame", 32'(miso_oe), 32'h0);
    cs = 1'b1;
    tick(4);
    check("R7 miso_oe high when selected", 32'(miso_oe), 32'h1);
    cs = 1'b0;
    tick(4);
    check("R7 miso_oe low when deselected", 32'(miso_oe), 32'h0);

    // R6: write visible before chip select falls
    run_frame({1'b1, 6'd20, 1'b0, 24'h0F0F0F}, 32, 1'b1, rx, extra);
    int_read(6'd20, rd);
    check("R6 write visible with cs high", 32'(rd), 32'h0F0F0F);
    check("R6 cs still high", 32'(cs), 32'h1);
    cs = 1'b0;
    tick(8);

    // R8: read of 20 leaves it intact and returns it
    run_frame({1'b0, 6'd20, 25'h0}, 32, 1'b0, rx, extra);
    check("R3 read reg 20", 32'(rx[23:0]), 32'h0F0F0F);
    int_read(6'd20, rd);
    check("R8 reg 20 after read", 32'(rd), 32'h0F0F0F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule